// File: doc/BRIEF.md
# Serial Control Register Receiver

This block sits on a two-wire serial control bus and lets a host load a bank of sixteen 8-bit configuration registers. It oversamples the clock and data lines on the system clock, spots start and stop conditions, and answers only to the device address `1000001`. A write transaction carries the device address, then one register index, then one or more data bytes. Every data byte lands in the register that the index selected. The block never advances the index on its own.

The slave acknowledges a byte by pulling the data line low for the ninth bus clock. The bus wiring is expected to be open-drain. The block therefore drives only an output-enable, and the pad pulls the line low while that enable is high. A byte that cannot be accepted gets no acknowledge. Such bytes are: an address for another device, a read request, or a register index of 16 or more. After such a byte the slave stays off the bus until the next start. All sixteen registers are presented in parallel to the rest of the chip. On reset each register takes its own fixed power-up value.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, register k appears on `regs_o[8k+7:8k]` and the registers hold: index 0 = 0x40, index 1 = 0x14, index 7 = 0x40, index 8 = 0x40, index 10 = 0x05, index 11 = 0x20, index 13 = 0x0F, every other index = 0x00.
- R2: An address byte whose upper seven bits (sent MSB first) are 1000001 and whose last bit is 0 (write) is acknowledged. The acknowledge is SDA held low while SCL is high in the ninth clock.
- R3: An address byte with any other 7-bit address gets no acknowledge, and the bytes that follow in that transaction change no register.
- R4: An address byte of 1000001 with its last bit at 1 (read) gets no acknowledge, and the following bytes change no register.
- R5: The byte after an accepted address is the register index. Values 0x00 to 0x0F are acknowledged. Values 0x10 to 0xFF are not acknowledged, and the following data bytes change no register.
- R6: A data byte after an accepted index is acknowledged and is written into the register at that index. No other register changes.
- R7: Further data bytes in the same transaction are each acknowledged, and each overwrites the same register. The index is not incremented, so the neighbouring registers keep their values.
- R8: After any unacknowledged byte, the slave acknowledges nothing and writes nothing until the next start condition.
- R9: A start condition (SDA falling while SCL is high) inside a transaction restarts the exchange. The next byte is treated as an address byte.
- R10: A stop condition (SDA rising while SCL is high) returns the slave to idle. A partly received byte is discarded and writes nothing.
- R11: The slave changes its SDA drive only while SCL is low. It releases SDA after SCL falls at the end of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial bus clock line as seen at the pad |
| sda_i | input | 1 | Serial bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| regs_o | output | 128 | Register bank, register k on bits 8k+7:8k |

## Verification
A wrong byte counter or a wrong phase state shows within one byte at the ports. The acknowledge either appears in the wrong bus clock or is missing in the ninth one. The release check a few system clocks after SCL falls catches an enable that is held too long. A wrong stored index, or a write enable that fires outside a data byte, shows in the parallel register outputs right after the stop. The bench compares the whole bank to a model after every transaction, so a stray write to a neighbouring register is caught in the same transaction.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_SKIP
  } rx_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_SUB,
    BK_DATA
  } byte_kind_e;

  // Power-up value of each control register
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h40; // sync mode set, override clear
      1:       return 8'h14;
      7:       return 8'h40;
      8:       return 8'h40; // gain loop: medium
      10:      return 8'h05;
      11:      return 8'h20; // colour loop: medium
      13:      return 8'h0F; // all output enables on
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s_o    = scl_ff[SYNC_STAGES-1];
  assign sda_s_o    = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_d;
  assign scl_fall_o = ~scl_s_o & scl_d;
  // data edges only count while the clock line stays high
  assign start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000001,
  parameter int         NUM_REGS = 16,
  parameter int         IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);

  rx_state_e  state_q;
  byte_kind_e kind_q;
  logic [3:0] cnt_q;
  logic [7:0] shreg_q;
  logic [IDX_W-1:0] idx_q;
  logic oe_q, wr_q;
  logic byte_ok;

  always_comb begin
    case (kind_q)
      BK_ADDR: byte_ok = (shreg_q[7:1] == DEV_ADDR) && !shreg_q[0];
      BK_SUB:  byte_ok = int'(shreg_q) < NUM_REGS;
      default: byte_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= '0;
      shreg_q <= '0;
      idx_q   <= '0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_RX;
        kind_q  <= BK_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              shreg_q <= {shreg_q[6:0], sda_i};
              cnt_q   <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (byte_ok) begin
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
                if (kind_q == BK_SUB)  idx_q <= shreg_q[IDX_W-1:0];
                if (kind_q == BK_DATA) wr_q  <= 1'b1;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_RX;
              kind_q  <= (kind_q == BK_ADDR) ? BK_SUB : BK_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = shreg_q;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] regs_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                val_q <= reg_default(g);
      else if (wr_en_i && wr_idx_i == IDX_W'(g))  val_q <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = val_q;
  end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1000001,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;

  i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_rx_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .regs_o    (regs_o)
  );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int REGS_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe_o,
  input logic              wr_en,
  input logic [REGS_W-1:0] regs_o
);

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s)); // R11

  AST_START_FREES_SDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o); // R9

  AST_STOP_FREES_SDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o); // R10

  AST_REG_CHANGE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(wr_en)); // R6

  AST_WRITE_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !wr_en); // R7

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.REGS_W(NUM_REGS*8)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe_o  (sda_oe_o),
  .wr_en     (wr_en),
  .regs_o    (regs_o)
);

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;

  localparam int H = 8;  // half bus period, system clocks
  localparam int Q = 6;  // settle after SCL falls
  localparam logic [6:0] DEV = 7'b1000001;

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_drv = 1'b1;
  logic sda_oe;
  logic [127:0] regs;
  wire sda_line = sda_drv & ~sda_oe;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [16];

  always #2.5 clk = ~clk;

  i2c_reg_slave u0 (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < 16; i++) chk(req, 32'(regs[i*8 +: 8]), 32'(exp_r[i]));
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; tick(H);
    scl = 1'b1;     tick(H);
    sda_drv = 1'b0; tick(H);
    scl = 1'b0;     tick(Q);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; tick(H);
    scl = 1'b1;     tick(H);
    sda_drv = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; tick(H);
    scl = 1'b1;  tick(H);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit a0;
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
    sda_drv = 1'b1; tick(H);
    scl = 1'b1;     tick(1);
    a0 = (sda_line == 1'b0);
    tick(H - 2);
    ack = a0 && (sda_line == 1'b0);
    tick(1);
    scl = 1'b0;     tick(Q);
    chk("R11 release after ninth clock", 32'(sda_oe), 32'd0);
  endtask

  initial begin
    bit a;
    exp_r = '{8'h40, 8'h14, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40,
              8'h40, 8'h00, 8'h05, 8'h20, 8'h00, 8'h0F, 8'h00, 8'h00};
    tick(4);
    rst_ni = 1'b1;
    tick(4);
    chk_bank("R1 reset values");
    chk("R1 sda idle", 32'(sda_oe), 32'd0);

    // R2 R5 R6: one write per index
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 11)) ^ 8'hA5;
      bus_start();
      send_byte({DEV, 1'b0}, a);  chk("R2 address ack", 32'(a), 32'd1);
      send_byte(8'(i), a);        chk("R5 index ack", 32'(a), 32'd1);
      send_byte(v, a);            chk("R6 data ack", 32'(a), 32'd1);
      bus_stop();
      exp_r[i] = v;
      chk_bank("R6 register write");
    end

    // R7: several data bytes, same index
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R2 address ack", 32'(a), 32'd1);
    send_byte(8'h05, a);       chk("R5 index ack", 32'(a), 32'd1);
    for (int j = 0; j < 3; j++) begin
      send_byte(8'(8'h71 + j * 8'h22), a); chk("R7 burst ack", 32'(a), 32'd1);
    end
    bus_stop();
    exp_r[5] = 8'h71 + 8'h44;
    chk_bank("R7 same register overwritten");

    // R3 R8: every other device address
    for (int ad = 0; ad < 128; ad++) begin
      if (7'(ad) == DEV) continue;
      bus_start();
      send_byte({7'(ad), 1'b0}, a); chk("R3 foreign address nack", 32'(a), 32'd0);
      send_byte(8'h03, a);          chk("R8 silent after nack", 32'(a), 32'd0);
      send_byte(8'hEE, a);          chk("R8 silent after nack", 32'(a), 32'd0);
      bus_stop();
      chk("R3 no write", 32'(regs[3*8 +: 8]), 32'(exp_r[3]));
    end
    chk_bank("R3 bank intact");

    // R4: read request
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R4 read nack", 32'(a), 32'd0);
    send_byte(8'h02, a);       chk("R8 silent after nack", 32'(a), 32'd0);
    send_byte(8'h99, a);       chk("R8 silent after nack", 32'(a), 32'd0);
    bus_stop();
    chk_bank("R4 no write");

    // R5 R8: out-of-range indices
    for (int k = 0; k < 16; k++) begin
      bus_start();
      send_byte({DEV, 1'b0}, a);    chk("R2 address ack", 32'(a), 32'd1);
      send_byte(8'(16 + k * 15), a); chk("R5 bad index nack", 32'(a), 32'd0);
      send_byte(8'h5A, a);          chk("R8 silent after nack", 32'(a), 32'd0);
      bus_stop();
    end
    chk_bank("R5 no write");

    // R9: repeated start
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R2 address ack", 32'(a), 32'd1);
    send_byte(8'h02, a);       chk("R5 index ack", 32'(a), 32'd1);
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R9 address after restart", 32'(a), 32'd1);
    send_byte(8'h04, a);       chk("R9 index after restart", 32'(a), 32'd1);
    send_byte(8'h3C, a);       chk("R9 data after restart", 32'(a), 32'd1);
    bus_stop();
    exp_r[4] = 8'h3C;
    chk_bank("R9 restart write");

    // R10: stop inside a data byte
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R2 address ack", 32'(a), 32'd1);
    send_byte(8'h06, a);       chk("R5 index ack", 32'(a), 32'd1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    chk_bank("R10 partial byte dropped");
    chk("R10 sda released", 32'(sda_oe), 32'd0);
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R10 address after stop", 32'(a), 32'd1);
    send_byte(8'h06, a);       chk("R10 index after stop", 32'(a), 32'd1);
    send_byte(8'hC3, a);       chk("R10 data after stop", 32'(a), 32'd1);
    bus_stop();
    exp_r[6] = 8'hC3;
    chk_bank("R10 write after stop");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule